// File: doc/BRIEF.md
# Power-Fault Blink-Code LED Driver

This block drives a single front-panel LED from one of four sources chosen by a 2-bit mode held in a small internal register. The LED can be forced dark, forced lit, made to follow a user LED input, or act as a power indicator. The mode register loads from `mode_in` when `mode_wr` is high and resets to the power-indicator setting.

As a power indicator the LED stays lit while every monitored rail reports good. When a rail fails, the LED repeats a blink code inside a frame of eight equal slots. The code for the failing rail with the highest priority lights the first N slots of the frame, and the remaining slots stay dark. Each lit slot is on for its first half only, so an observer can count separate pulses. The six power-good inputs pass through a two-flop synchroniser. The code is picked up only where one frame ends and the next begins.

Top module: `pwr_blink_led`

## Requirements
- R1: With mode 0 (binary 00) loaded, `led` is 0 in every cycle.
- R2: With mode 3 (binary 11) loaded, `led` is 1 in every cycle.
- R3: With mode 2 (binary 10) loaded, `led` follows `user_led` combinationally in the same cycle.
- R4: Reset loads mode 1 (binary 01, power indicator). The mode register takes `mode_in` only on a clock edge where `mode_wr` is 1. A change on `mode_in` without `mode_wr` leaves `led` unaffected.
- R5: In mode 1, when the latched fault code is zero, meaning no rail was bad at the last frame boundary, `led` is steadily 1. The code also reads zero from reset until the first frame boundary.
- R6: `pg_in` is active-high power good. A 0 on bit k, with k from 0 to 5, gives a code of k+1 pulses per frame. The bit-to-rail assignment is PSGT on bit 0, DDR on bit 1, LP on bit 2, GT_L on bit 3, GT_R on bit 4 and PL on bit 5.
- R7: When several `pg_in` bits are 0, the lowest-numbered bad bit sets the code.
- R8: A slot lasts `SLOT_CYCLES` clocks and a frame lasts 8 slots. In mode 1 with a code N greater than 0, slot s with s < N is lit for its first `SLOT_CYCLES/2` clocks and dark for the rest of the slot. Slots N to 7 are dark.
- R9: `pg_in` passes through two flip-flops. The code is updated only on the clock edge that ends slot 7, so a change in `pg_in` during a frame does not alter the pulses of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Load strobe for the mode register |
| mode_in | input | 2 | Mode value: 0 off, 1 indicator, 2 user, 3 on |
| pg_in | input | 6 | Power-good inputs, 1 = good, bit order per R6 |
| user_led | input | 1 | User LED level passed through in mode 2 |
| led | output | 1 | LED drive, 1 = lit |

## Verification
Each power-good bit is cleared on its own, and the bench counts pulses and lit cycles over a whole frame. This shows that the bit-to-count mapping and the lit half-slot length are right. Combinations of bad bits check that the lowest-numbered bit has priority over higher-numbered ones. A fault raised in the middle of a frame checks that the code of the current frame holds and that the new code shows in the next frame. Writes of each mode, and changes on `mode_in` with no strobe, check both the selection of the LED source and the load-only-on-strobe rule.

// File: rtl/pwr_blink_led.sv
module pwr_blink_led #(
  parameter int SLOT_CYCLES = 12_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_in,
  input  logic [5:0] pg_in,
  input  logic       user_led,
  output logic       led
);
  localparam int CW   = $clog2(SLOT_CYCLES);
  localparam int HALF = SLOT_CYCLES / 2;
  localparam logic [CW-1:0] CYC_LAST = CW'(SLOT_CYCLES - 1);
  localparam logic [CW-1:0] CYC_HALF = CW'(HALF);

  logic [1:0]    mode_q;
  logic [5:0]    pg_s1, pg_s2;
  logic [CW-1:0] cyc;
  logic [2:0]    slot;
  logic [2:0]    code_q;
  logic [2:0]    fault;
  logic          slot_end, frame_end, ind_lit;

  assign slot_end  = (cyc == CYC_LAST);
  assign frame_end = slot_end && (slot == 3'd7);

  always_comb begin
    fault = 3'd0;
    for (int i = 5; i >= 0; i--)
      if (!pg_s2[i]) fault = 3'(i + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b01;
      pg_s1  <= '1;
      pg_s2  <= '1;
      cyc    <= '0;
      slot   <= '0;
      code_q <= '0;
    end else begin
      pg_s1 <= pg_in;
      pg_s2 <= pg_s1;
      if (mode_wr) mode_q <= mode_in;
      if (slot_end) begin
        cyc  <= '0;
        slot <= slot + 3'd1;
      end else begin
        cyc <= cyc + 1'b1;
      end
      if (frame_end) code_q <= fault;
    end
  end

  assign ind_lit = (code_q == 3'd0) || ((slot < code_q) && (cyc < CYC_HALF));

  always_comb begin
    case (mode_q)
      2'b00:   led = 1'b0;
      2'b01:   led = ind_lit;
      2'b10:   led = user_led;
      default: led = 1'b1;
    endcase
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_q)); // R4
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(code_q)); // R9
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= 3'd6); // R6
  AST_PRIO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !pg_s2[0]) |=> (code_q == 3'd1)); // R7
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (cyc == '0) && (slot == $past(slot) + 3'd1)); // R8
  AST_DARK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && code_q != 3'd0 && slot >= code_q) |-> !led); // R8
endmodule

// File: tb/pwr_blink_led_tb.sv
module pwr_blink_led_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 6;
  localparam int HALF = SLOT / 2;

  logic clk = 0, rst_n = 0, mode_wr = 0, user_led = 0;
  logic [1:0] mode_in = 2'b00;
  logic [5:0] pg_in = 6'h3f;
  logic led;

  int checks = 0, errors = 0;
  bit finished = 0;

  int m_mode, m_cyc, m_slot, m_code;
  logic [5:0] syncq[$];

  pwr_blink_led #(.SLOT_CYCLES(SLOT)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .pg_in(pg_in), .user_led(user_led), .led(led));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int first_bad(logic [5:0] p);
    for (int i = 0; i < 6; i++) if (!p[i]) return i + 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 1; m_cyc = 0; m_slot = 0; m_code = 0;
      syncq = '{6'h3f, 6'h3f};
    end else begin
      if (m_cyc == SLOT - 1 && m_slot == 7) m_code = first_bad(syncq[0]);
      if (m_cyc == SLOT - 1) begin m_cyc = 0; m_slot = (m_slot + 1) % 8; end
      else m_cyc++;
      void'(syncq.pop_front());
      syncq.push_back(pg_in);
      if (mode_wr) m_mode = int'(mode_in);
    end
  end

  function automatic logic exp_led();
    case (m_mode)
      0: return 1'b0;
      2: return user_led;
      3: return 1'b1;
      default: return (m_code == 0) || (m_slot < m_code && m_cyc < HALF);
    endcase
  endfunction

  task automatic check(string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s led act=%b exp=%b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic check_int(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    case (m_mode)
      0: check("R1", led, exp_led());
      2: check("R3", led, exp_led());
      3: check("R2", led, exp_led());
      default: check(m_code == 0 ? "R5" : "R6", led, exp_led());
    endcase
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_mode(logic [1:0] v);
    mode_in = v; mode_wr = 1; step(1); mode_wr = 0;
  endtask

  task automatic to_frame_start();
    do @(negedge clk); while (!(m_slot == 0 && m_cyc == 0));
  endtask

  task automatic count_frame(string tag, int exp_pulses, int chg_at,
                             logic [5:0] chg_pg);
    int pulses = 0, lit = 0;
    logic prev = 0;
    to_frame_start();
    for (int c = 0; c < 8 * SLOT; c++) begin
      if (led) begin lit++; if (c == 0 || !prev) pulses++; end
      prev = led;
      if (c == chg_at) begin #1; pg_in = chg_pg; end
      @(negedge clk);
    end
    if (exp_pulses == 0) check_int({tag, " lit"}, lit, 8 * SLOT);
    else begin
      check_int({tag, " pulses"}, pulses, exp_pulses);
      check_int({"R8 lit of ", tag}, lit, exp_pulses * HALF);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    @(negedge clk);
    check("R4 reset mode", led, 1'b1);
    count_frame("R5", 0, -1, 6'h3f);
    for (int k = 0; k < 6; k++) begin
      pg_in = ~(6'(1) << k);
      step(3);
      count_frame("R6", k + 1, -1, 6'h00);
    end
    pg_in = 6'b101010; step(3);
    count_frame("R7", 1, -1, 6'h00);
    pg_in = 6'b110011; step(3);
    count_frame("R7", 3, -1, 6'h00);
    pg_in = 6'b111101; step(3);
    count_frame("R9", 2, 20, 6'b111100);
    count_frame("R9 next", 1, -1, 6'h00);
    pg_in = 6'h3f; step(3);
    count_frame("R5 recover", 0, -1, 6'h3f);
    write_mode(2'b00); step(20);
    write_mode(2'b11); step(10);
    mode_in = 2'b00; step(5);
    @(negedge clk);
    check("R4 no strobe", led, 1'b1);
    step(1);
    write_mode(2'b10);
    for (int i = 0; i < 12; i++) begin user_led = i[0] ^ i[2]; step(1); end
    write_mode(2'b01);
    pg_in = 6'b111011; step(3);
    count_frame("R6 after modes", 3, -1, 6'h00);
    step(2);
    finish_run();
  end
endmodule